// File: doc/BRIEF.md
# Dual-Clock Ready-Flag FIFO

This block moves 18-bit words between two clock domains that may be unrelated or share one clock. The writer offers a word with a chip-select, a direction select and an enable. The word is accepted only while the block reports input-ready. The reader sees the oldest word already waiting on its data output, and output-ready marks that word as fresh. A read consumes that word and exposes the next one in the same edge. When the queue runs dry, the last word stays on the output.

Both sides share one active-low asynchronous reset. The reset counts as complete only after each clock has ticked four times while it is held. The write side reports a half-full flag and a fill level. The level counts every word not yet taken by the reader, including the word parked on the output. The read side drives an output-enable that tells a pad ring when the read bus should drive.

Top module: `rdyfifo_top`

## Requirements
- R1: The FIFO holds 512 words of 18 bits; 512 words written back to back are returned to the reader in the order written.
- R2: A word is accepted on a rising `wr_clk_i` edge only when `wr_cs_ni`=0, `wr_sel_i`=1, `wr_en_i`=1 and `in_rdy_o`=1; any other combination leaves `level_o` unchanged.
- R3: A word is consumed on a rising `rd_clk_i` edge only when `rd_cs_ni`=0, `rd_sel_i`=0, `rd_en_i`=1 and `out_rdy_o`=1; otherwise `rd_data_o` and `out_rdy_o` keep their values.
- R4: A word written into an empty FIFO appears on `rd_data_o` in the same cycle `out_rdy_o` rises, which is the third rising `rd_clk_i` edge after the write edge.
- R5: After the FIFO is read empty, `out_rdy_o` is 0 and `rd_data_o` keeps the last word read until `out_rdy_o` rises again.
- R6: `rd_oe_o` is 1 exactly when `rd_cs_ni`=0 and `rd_sel_i`=0.
- R7: While `rst_ni` is low, `in_rdy_o`, `out_rdy_o` and `half_full_o` are 0 and `level_o` is 0. After a completed reset, `in_rdy_o` is still 0 after the first rising `wr_clk_i` edge with `rst_ni` high, and it is 1 after the second.
- R8: A reset held low for fewer than four rising edges of a clock does not complete. `in_rdy_o` stays 0, no word is accepted, and `out_rdy_o` stays 0 until a full reset is applied.
- R9: `half_full_o` is 1 when `level_o` is 256 or more, and 0 when it is 255 or less.
- R10: `in_rdy_o` is 0 while 512 words are held. It returns to 1 within four `wr_clk_i` edges after a word is consumed.
- R11: `level_o` reports the number of words not yet consumed by the reader, in the range 0 to 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write-side clock |
| rd_clk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Shared asynchronous reset, active low |
| wr_cs_ni | input | 1 | Write-side chip select, active low |
| wr_sel_i | input | 1 | Write-side direction select, 1 selects writing |
| wr_en_i | input | 1 | Write enable |
| wr_data_i | input | 18 | Word to store |
| in_rdy_o | output | 1 | Space available, write-clock domain |
| half_full_o | output | 1 | 256 or more words held |
| level_o | output | 10 | Unconsumed word count, write-clock domain |
| rd_cs_ni | input | 1 | Read-side chip select, active low |
| rd_sel_i | input | 1 | Read-side direction select, 0 selects reading |
| rd_en_i | input | 1 | Read enable |
| rd_data_o | output | 18 | Oldest word, held after the queue empties |
| out_rdy_o | output | 1 | Fresh word on rd_data_o, read-clock domain |
| rd_oe_o | output | 1 | Read bus drive enable |

## Verification
A table walks all eight combinations of chip select, direction and enable on the write side. A word must be stored for exactly one of them. The same deliberate mismatches are then applied to the read side and must leave the output word and its flag unchanged. A single word is written into an empty queue to measure the fall-through edge exactly. A 512-word fill tells the half-full boundary (255 versus 256) apart from the full stop, and it checks that an extra write is refused. Draining that fill checks the order and the held last word. A reset only two edges long must leave the block dead, while a full one must bring input-ready up on the second edge.

// File: rtl/rdyfifo_pkg.sv
package rdyfifo_pkg;
  timeunit 1ns; timeprecision 1ps;
  localparam int unsigned RF_DATA_W    = 18;
  localparam int unsigned RF_ADDR_W    = 9;
  localparam int unsigned RF_SYNC_N    = 2;
  localparam int unsigned RF_RST_EDGES = 4;
endpackage

// File: rtl/rdyfifo_sync.sv
module rdyfifo_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  timeunit 1ns; timeprecision 1ps;
  localparam int unsigned CW = W * STAGES;

  logic [CW-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[CW-W-1:0], d_i};
  end

  assign q_o = chain_q[CW-1 -: W];
endmodule

// File: rtl/rdyfifo_rst_gate.sv
// Counts clock edges seen while reset is low; releases the domain only when
// both this domain and its peer have counted enough.
module rdyfifo_rst_gate #(
  parameter int unsigned EDGES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic peer_ok_i,
  output logic ok_o,
  output logic run_o
);
  timeunit 1ns; timeprecision 1ps;
  localparam int unsigned EW = EDGES - 1;

  logic [EW-1:0] edges_q;
  logic          ok_q;
  logic          run_q;

  // thermometer fill: settles after EW low edges from any start value
  always_ff @(posedge clk_i) begin
    if (rst_ni) edges_q <= '0;
    else        edges_q <= {edges_q[EW-2:0], 1'b1};
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) ok_q <= edges_q[EW-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= ok_q & peer_ok_i;
  end

  assign ok_o  = ok_q;
  assign run_o = run_q;
endmodule

// File: rtl/rdyfifo_wr.sv
module rdyfifo_wr #(
  parameter int unsigned AW = 9
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic        push_i,
  input  logic [AW:0] rgray_i,
  output logic        we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0] wgray_o,
  output logic        ir_o,
  output logic        hf_o,
  output logic [AW:0] level_o
);
  timeunit 1ns; timeprecision 1ps;
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned HALF  = 1 << (AW - 1);

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d, rbin_s, level_q, level_d;
  logic          ir_q, hf_q, full_d, we;

  assign we     = push_i & ir_q;
  assign wbin_d = wbin_q + PW'(we);
  assign wgray_d = wbin_d ^ (wbin_d >> 1);

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_i >> i);
  end

  assign full_d  = (wgray_d == {~rgray_i[PW-1:PW-2], rgray_i[PW-3:0]});
  assign level_d = wbin_d - rbin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ir_q    <= 1'b0;
      hf_q    <= 1'b0;
      level_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      ir_q    <= run_i & ~full_d;
      hf_q    <= (level_d >= PW'(HALF));
      level_q <= level_d;
    end
  end

  assign we_o    = we;
  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;
  assign ir_o    = ir_q;
  assign hf_o    = hf_q;
  assign level_o = level_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q == PW'(DEPTH)) |-> !ir_q); // R10
  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= PW'(DEPTH)); // R11
endmodule

// File: rtl/rdyfifo_rd.sv
module rdyfifo_rd #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          take_req_i,
  input  logic [AW:0]   wgray_i,
  input  logic [DW-1:0] mem_data_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic          rdy_o,
  output logic [DW-1:0] data_o
);
  timeunit 1ns; timeprecision 1ps;
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] rbin_q, rbin_d, wbin_s, rcons_d, rgray_q;
  logic [DW-1:0] data_q;
  logic          ov_q, ov_d, has, take, fetch;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_i >> i);
  end

  assign has    = run_i & (wbin_s != rbin_q);
  assign take   = take_req_i & ov_q;
  assign fetch  = has & (~ov_q | take);
  assign rbin_d = rbin_q + PW'(fetch);
  assign ov_d   = fetch | (ov_q & ~take);
  // pointer seen by the writer counts the parked output word as still held
  assign rcons_d = rbin_d - PW'(ov_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      ov_q    <= 1'b0;
      data_q  <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rcons_d ^ (rcons_d >> 1);
      ov_q    <= ov_d;
      if (fetch) data_q <= mem_data_i;
    end
  end

  assign raddr_o = rbin_q[AW-1:0];
  assign rgray_o = rgray_q;
  assign rdy_o   = ov_q;
  assign data_o  = data_q;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ov_q |-> $stable(data_q)); // R5
  AST_RISE_NEEDS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ov_q) |-> $past(has)); // R4
  AST_READY_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_q && !take_req_i) |=> ov_q); // R3
endmodule

// File: rtl/rdyfifo_top.sv
module rdyfifo_top
  import rdyfifo_pkg::*;
#(
  parameter int unsigned DATA_W = RF_DATA_W,
  parameter int unsigned ADDR_W = RF_ADDR_W
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              wr_cs_ni,
  input  logic              wr_sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              in_rdy_o,
  output logic              half_full_o,
  output logic [ADDR_W:0]   level_o,
  input  logic              rd_cs_ni,
  input  logic              rd_sel_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              out_rdy_o,
  output logic              rd_oe_o
);
  timeunit 1ns; timeprecision 1ps;
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned PW    = ADDR_W + 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic              we, wr_push, rd_take_req;
  logic              ok_w, ok_r, ok_w_s, ok_r_s, run_w, run_r;

  assign wr_push     = ~wr_cs_ni & wr_sel_i & wr_en_i;
  assign rd_take_req = ~rd_cs_ni & ~rd_sel_i & rd_en_i;
  assign rd_oe_o     = ~rd_cs_ni & ~rd_sel_i;

  rdyfifo_rst_gate #(.EDGES(RF_RST_EDGES)) u_gate_w (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .peer_ok_i(ok_r_s), .ok_o(ok_w), .run_o(run_w));
  rdyfifo_rst_gate #(.EDGES(RF_RST_EDGES)) u_gate_r (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .peer_ok_i(ok_w_s), .ok_o(ok_r), .run_o(run_r));

  rdyfifo_sync #(.W(1), .STAGES(RF_SYNC_N)) u_ok_to_w (
    .clk_i(wr_clk_i), .rst_ni(1'b1), .d_i(ok_r), .q_o(ok_r_s));
  rdyfifo_sync #(.W(1), .STAGES(RF_SYNC_N)) u_ok_to_r (
    .clk_i(rd_clk_i), .rst_ni(1'b1), .d_i(ok_w), .q_o(ok_w_s));

  rdyfifo_sync #(.W(PW), .STAGES(RF_SYNC_N)) u_rptr_to_w (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_s));
  rdyfifo_sync #(.W(PW), .STAGES(RF_SYNC_N)) u_wptr_to_r (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_s));

  rdyfifo_wr #(.AW(ADDR_W)) u_wr (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .run_i(run_w), .push_i(wr_push),
    .rgray_i(rgray_s), .we_o(we), .waddr_o(waddr), .wgray_o(wgray),
    .ir_o(in_rdy_o), .hf_o(half_full_o), .level_o(level_o));

  always_ff @(posedge wr_clk_i) begin
    if (we) mem_q[waddr] <= wr_data_i;
  end

  rdyfifo_rd #(.AW(ADDR_W), .DW(DATA_W)) u_rd (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .run_i(run_r), .take_req_i(rd_take_req),
    .wgray_i(wgray_s), .mem_data_i(mem_q[raddr]), .raddr_o(raddr),
    .rgray_o(rgray), .rdy_o(out_rdy_o), .data_o(rd_data_o));
endmodule

// File: tb/sim_rdyfifo_top.sv
module sim_rdyfifo_top;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_cs_ni = 1'b1, wr_sel_i = 1'b0, wr_en_i = 1'b0;
  logic [17:0] wr_data_i = '0;
  logic        rd_cs_ni = 1'b1, rd_sel_i = 1'b1, rd_en_i = 1'b0;
  logic        in_rdy_o, half_full_o, out_rdy_o, rd_oe_o;
  logic [9:0]  level_o;
  logic [17:0] rd_data_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz, both domains coincident

  rdyfifo_top u0 (
    .wr_clk_i(clk), .rd_clk_i(clk), .rst_ni(rst_ni),
    .wr_cs_ni(wr_cs_ni), .wr_sel_i(wr_sel_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .in_rdy_o(in_rdy_o), .half_full_o(half_full_o), .level_o(level_o),
    .rd_cs_ni(rd_cs_ni), .rd_sel_i(rd_sel_i), .rd_en_i(rd_en_i),
    .rd_data_o(rd_data_o), .out_rdy_o(out_rdy_o), .rd_oe_o(rd_oe_o));

  // {expect_accept, cs_n, sel, en, data}
  localparam logic [21:0] VEC [10] = '{
    {1'b1, 1'b0, 1'b1, 1'b1, 18'h00101},
    {1'b0, 1'b1, 1'b1, 1'b1, 18'h00202},
    {1'b0, 1'b0, 1'b0, 1'b1, 18'h00303},
    {1'b0, 1'b0, 1'b1, 1'b0, 18'h00404},
    {1'b1, 1'b0, 1'b1, 1'b1, 18'h00505},
    {1'b0, 1'b1, 1'b0, 1'b0, 18'h00606},
    {1'b0, 1'b1, 1'b1, 1'b0, 18'h00707},
    {1'b0, 1'b1, 1'b0, 1'b1, 18'h00808},
    {1'b0, 1'b0, 1'b0, 1'b0, 18'h00909},
    {1'b1, 1'b0, 1'b1, 1'b1, 18'h00A0A}
  };

  function automatic logic [17:0] pat(input int i);
    return 18'((i * 1031 + 7) & 32'h3FFFF);
  endfunction

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_idle();
    wr_cs_ni = 1'b1; wr_sel_i = 1'b0; wr_en_i = 1'b0;
  endtask

  task automatic rd_set(input logic cs_n, input logic sel, input logic en);
    rd_cs_ni = cs_n; rd_sel_i = sel; rd_en_i = en;
  endtask

  initial begin
    int cnt;
    int bad;
    logic [17:0] w;
    tick(8);
    check("R7 in_rdy in reset", 32'(in_rdy_o), 0);
    check("R7 out_rdy in reset", 32'(out_rdy_o), 0);
    check("R7 half_full in reset", 32'(half_full_o), 0);
    check("R7 level in reset", 32'(level_o), 0);
    rst_ni = 1'b1;
    tick();
    check("R7 in_rdy first edge", 32'(in_rdy_o), 0);
    tick();
    check("R7 in_rdy second edge", 32'(in_rdy_o), 1);

    // R6 output enable decode
    rd_set(1'b0, 1'b0, 1'b0); #1 check("R6 oe cs0 sel0", 32'(rd_oe_o), 1);
    rd_set(1'b0, 1'b1, 1'b0); #1 check("R6 oe cs0 sel1", 32'(rd_oe_o), 0);
    rd_set(1'b1, 1'b0, 1'b0); #1 check("R6 oe cs1 sel0", 32'(rd_oe_o), 0);
    rd_set(1'b1, 1'b1, 1'b0); #1 check("R6 oe cs1 sel1", 32'(rd_oe_o), 0);

    // R2 write qualification table
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      wr_cs_ni = VEC[i][20]; wr_sel_i = VEC[i][19]; wr_en_i = VEC[i][18];
      wr_data_i = VEC[i][17:0];
      tick();
      cnt += int'(VEC[i][21]);
      check($sformatf("R2 level after vector %0d", i), 32'(level_o), 32'(cnt));
    end
    wr_idle();
    tick(4);
    check("R4 first word ready", 32'(out_rdy_o), 1);
    check("R4 first word value", 32'(rd_data_o), 32'h00101);

    // R3 mismatched read qualifiers do nothing
    rd_set(1'b1, 1'b0, 1'b1); tick();
    check("R3 cs high keeps word", 32'(rd_data_o), 32'h00101);
    rd_set(1'b0, 1'b1, 1'b1); tick();
    check("R3 sel high keeps word", 32'(rd_data_o), 32'h00101);
    rd_set(1'b0, 1'b0, 1'b0); tick();
    check("R3 en low keeps word", 32'(rd_data_o), 32'h00101);
    check("R3 ready kept", 32'(out_rdy_o), 1);
    rd_set(1'b0, 1'b0, 1'b1); tick();
    check("R3 read advances", 32'(rd_data_o), 32'h00505);
    tick();
    check("R3 read advances again", 32'(rd_data_o), 32'h00A0A);
    tick();
    check("R5 ready drops when empty", 32'(out_rdy_o), 0);
    check("R5 last word held", 32'(rd_data_o), 32'h00A0A);
    tick(4);
    rd_set(1'b1, 1'b1, 1'b0);
    check("R5 last word still held", 32'(rd_data_o), 32'h00A0A);
    check("R5 ready still low", 32'(out_rdy_o), 0);
    check("R11 level drained", 32'(level_o), 0);

    // R4 exact fall-through latency
    wr_cs_ni = 1'b0; wr_sel_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 18'h3C3C3;
    tick();
    wr_idle();
    tick(2);
    check("R4 not ready after two edges", 32'(out_rdy_o), 0);
    check("R5 old word until new ready", 32'(rd_data_o), 32'h00A0A);
    tick();
    check("R4 ready on third edge", 32'(out_rdy_o), 1);
    check("R4 word with ready", 32'(rd_data_o), 32'h3C3C3);
    rd_set(1'b0, 1'b0, 1'b1); tick(); rd_set(1'b1, 1'b1, 1'b0);
    tick(5);

    // R1/R9/R10/R11 full fill
    wr_cs_ni = 1'b0; wr_sel_i = 1'b1; wr_en_i = 1'b1;
    for (int i = 0; i < 512; i++) begin
      wr_data_i = pat(i);
      tick();
      if (i == 254) begin
        check("R9 half_full at 255", 32'(half_full_o), 0);
        check("R11 level 255", 32'(level_o), 255);
      end
      if (i == 255) check("R9 half_full at 256", 32'(half_full_o), 1);
    end
    check("R10 in_rdy low when full", 32'(in_rdy_o), 0);
    check("R11 level 512", 32'(level_o), 512);
    wr_data_i = 18'h3FFFF;
    tick();
    wr_idle();
    tick(2);
    check("R2 write refused when full", 32'(level_o), 512);

    check("R1 first word", 32'(rd_data_o), 32'(pat(0)));
    rd_set(1'b0, 1'b0, 1'b1); tick(); rd_set(1'b1, 1'b1, 1'b0);
    tick(4);
    check("R10 in_rdy back after read", 32'(in_rdy_o), 1);
    check("R11 level 511", 32'(level_o), 511);
    check("R9 half_full at 511", 32'(half_full_o), 1);
    bad = 0;
    rd_set(1'b0, 1'b0, 1'b1);
    for (int i = 1; i < 512; i++) begin
      if (!out_rdy_o || rd_data_o !== pat(i)) bad++;
      tick();
    end
    rd_set(1'b1, 1'b1, 1'b0);
    check("R1 order of 512 words", 32'(bad), 0);
    check("R5 empty after drain", 32'(out_rdy_o), 0);
    check("R5 last of fill held", 32'(rd_data_o), 32'(pat(511)));
    tick(5);
    check("R11 level after drain", 32'(level_o), 0);
    check("R9 half_full after drain", 32'(half_full_o), 0);

    // R8 short reset leaves block dead
    rst_ni = 1'b0; tick(2); rst_ni = 1'b1;
    tick(6);
    check("R8 in_rdy after short reset", 32'(in_rdy_o), 0);
    wr_cs_ni = 1'b0; wr_sel_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 18'h12345;
    tick();
    wr_idle();
    tick(5);
    check("R8 no write after short reset", 32'(level_o), 0);
    check("R8 no ready after short reset", 32'(out_rdy_o), 0);

    rst_ni = 1'b0; tick(8); rst_ni = 1'b1;
    tick();
    check("R7 in_rdy first edge again", 32'(in_rdy_o), 0);
    tick();
    check("R7 in_rdy second edge again", 32'(in_rdy_o), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule